// File: doc/BRIEF.md
# Busy-Status Read Path for an Emulated Flash Device

This block is the read-data selector of an emulated flash memory. While the device performs an internal byte program or a full erase, ordinary reads must not return array contents. They return status encodings that let host software detect when the operation is done. The command decoder and the storage array sit outside the block. They appear here as plain inputs: a busy flag, an erase-versus-program qualifier, the last loaded address and byte, and the array byte at the current read address.

Two completion signals are reported at once. Bit 7 carries a polling value: the inverse of the loaded byte's top bit when the loaded address is read during a program, and 0 on any read during an erase. Bit 6 flips on every new read access for the whole operation, whatever the address. When the busy flag drops, bit 6 stops changing and every bit reverts to array data. Software can start either kind of polling at any point.

A read access begins when chip select and output enable are both low with write enable high. Every such beginning counts as one read strobe, whichever of the two lines caused it. All decisions are registered, so the output byte and its enable appear one clock after the inputs that produced them. Instead of a high-impedance state, a separate output-enable signal is driven low.

Top module: `flash_status_rdpath`

## Requirements
- R1: During reset and directly after it, dout_oe is 0 and dout is 0.
- R2: With op_busy low, a read (ce_n=0, oe_n=0, we_n=1) shows dout_oe=1 and dout equal to arr_data one clock later. When no read is active, dout_oe=0 and dout=0 one clock later.
- R3: During a byte program (op_busy=1, op_erase=0), a read of the address equal to ld_addr returns the inverse of ld_data bit 7 on dout bit 7.
- R4: During a byte program, a read of any other address returns arr_data bit 7 on dout bit 7.
- R5: During an erase (op_busy=1, op_erase=1), dout bit 7 reads 0 at every address.
- R6: While op_busy is high, every new read access inverts dout bit 6 relative to the previous access. The first access after op_busy rises returns 1. Bits 5..0 always show arr_data.
- R7: An access held active over several clocks counts once. Bit 6 stays constant while the access lasts.
- R8: A new access started by ce_n falling while oe_n stays low advances bit 6, exactly as one started by oe_n falling.
- R9: Clocks without a read leave the bit 6 state unchanged. After op_busy falls, reads return true array data on all bits. A new operation restarts bit 6 from its initial state.
- R10: With we_n low, no read takes place: dout_oe stays 0 and bit 6 does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_busy | input | 1 | Internal program or erase in progress |
| op_erase | input | 1 | 1 = operation is an erase, 0 = byte program |
| ld_addr | input | ADDR_W | Address of the last loaded byte |
| ld_data | input | 8 | Last loaded data byte |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| rd_addr | input | ADDR_W | Read address |
| arr_data | input | 8 | Array byte at rd_addr |
| dout | output | 8 | Read data or status byte |
| dout_oe | output | 1 | Output data valid/driven |

## Verification
The bench sweeps every address of a 4-bit configuration under several loaded bytes, for programs and erases. A design that compared the wrong address, or ignored the erase qualifier, would show the wrong bit 7 at some swept address. Accesses that are held over several clocks catch a toggle that counts clocks instead of accesses. Strobes from chip select alone, and idle gaps between reads, catch a toggle that misses strobes or drifts without reads. A restarted operation exposes a toggle that is never reinitialised. Reads with write enable low, and reads after completion, reveal status that leaks into normal reads.

// File: rtl/fsr_pkg.sv
`timescale 1ns/1ps
package fsr_pkg;
    typedef enum logic {
        OP_PROGRAM = 1'b0,
        OP_ERASE   = 1'b1
    } op_kind_t;

    // Toggle state carried between clocks
    typedef struct packed {
        logic busy;
        logic tog;
    } tog_state_t;
endpackage

// File: rtl/fsr_strobe_det.sv
`timescale 1ns/1ps
module fsr_strobe_det (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic oe_n,
    input  logic we_n,
    output logic rd_en,
    output logic rd_strobe
);
    typedef struct packed {
        logic rd_en;
    } det_state_t;

    det_state_t st_d, st_q;

    always_comb begin
        rd_en     = !ce_n && !oe_n && we_n;
        st_d      = st_q;
        st_d.rd_en = rd_en;
        rd_strobe = rd_en && !st_q.rd_en;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // A strobe never repeats on consecutive clocks
    assert_strobe_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe |=> !rd_strobe);
endmodule

// File: rtl/fsr_toggle.sv
`timescale 1ns/1ps
module fsr_toggle
    import fsr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    input  logic rd_strobe,
    output logic tog_now
);
    tog_state_t st_d, st_q;
    logic       op_begin;

    always_comb begin
        op_begin  = busy && !st_q.busy;
        st_d      = st_q;
        st_d.busy = busy;
        if (op_begin)
            st_d.tog = rd_strobe;          // restart at 0, then count this read
        else if (busy && rd_strobe)
            st_d.tog = !st_q.tog;
        tog_now = st_d.tog;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_flip_per_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && st_q.busy && rd_strobe) |=> (st_q.tog != $past(st_q.tog)));

    assert_hold_no_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_strobe && !(busy && !st_q.busy)) |=> $stable(st_q.tog));

    assert_idle_no_flip_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy) |=> $stable(st_q.tog));

    assert_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !st_q.busy && !rd_strobe) |=> !st_q.tog);
endmodule

// File: rtl/fsr_out_mux.sv
`timescale 1ns/1ps
module fsr_out_mux
    import fsr_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              busy,
    input  op_kind_t          kind,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic              ld_top,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] arr_data,
    input  logic              tog_now,
    output logic [DATA_W-1:0] dout,
    output logic              dout_oe
);
    localparam int POLL_BIT = DATA_W - 1;
    localparam int TOG_BIT  = DATA_W - 2;

    typedef struct packed {
        logic              oe;
        logic [DATA_W-1:0] data;
    } out_state_t;

    out_state_t st_d, st_q;

    always_comb begin
        st_d    = '0;
        st_d.oe = rd_en;
        if (rd_en) begin
            st_d.data = arr_data;
            if (busy) begin
                st_d.data[TOG_BIT] = tog_now;
                if (kind == OP_ERASE)
                    st_d.data[POLL_BIT] = 1'b0;
                else if (rd_addr == ld_addr)
                    st_d.data[POLL_BIT] = !ld_top;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout    = st_q.data;
    assign dout_oe = st_q.oe;

    assert_poll_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && busy && kind == OP_PROGRAM && rd_addr == ld_addr)
        |=> (dout[POLL_BIT] == !$past(ld_top)));

    assert_poll_other_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && busy && kind == OP_PROGRAM && rd_addr != ld_addr)
        |=> (dout[POLL_BIT] == $past(arr_data[POLL_BIT])));

    assert_erase_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && busy && kind == OP_ERASE) |=> !dout[POLL_BIT]);

    assert_low_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> (dout[TOG_BIT-1:0] == $past(arr_data[TOG_BIT-1:0])));
endmodule

// File: rtl/flash_status_rdpath.sv
`timescale 1ns/1ps
module flash_status_rdpath
    import fsr_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_busy,
    input  logic              op_erase,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [7:0]        ld_data,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        arr_data,
    output logic [7:0]        dout,
    output logic              dout_oe
);
    localparam int DATA_W = 8;

    logic     rd_en;
    logic     rd_strobe;
    logic     tog_now;
    op_kind_t kind;
    logic     unused_ld_bits;

    assign kind           = op_kind_t'(op_erase);
    assign unused_ld_bits = ^ld_data[DATA_W-2:0];

    fsr_strobe_det u_det (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce_n      (ce_n),
        .oe_n      (oe_n),
        .we_n      (we_n),
        .rd_en     (rd_en),
        .rd_strobe (rd_strobe)
    );

    fsr_toggle u_tog (
        .clk       (clk),
        .rst_n     (rst_n),
        .busy      (op_busy),
        .rd_strobe (rd_strobe),
        .tog_now   (tog_now)
    );

    fsr_out_mux #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_mux (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .busy     (op_busy),
        .kind     (kind),
        .ld_addr  (ld_addr),
        .ld_top   (ld_data[DATA_W-1]),
        .rd_addr  (rd_addr),
        .arr_data (arr_data),
        .tog_now  (tog_now),
        .dout     (dout),
        .dout_oe  (dout_oe)
    );

    assert_true_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !op_busy) |=> (dout_oe && dout == $past(arr_data)));

    assert_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en) |=> (!dout_oe && dout == '0));

    assert_write_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n) |=> !dout_oe);
endmodule

// File: tb/sim_flash_status_rdpath.sv
`timescale 1ns/1ps
module sim_flash_status_rdpath;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          op_busy, op_erase;
    logic [AW-1:0] ld_addr, rd_addr;
    logic [7:0]    ld_data, arr_data, dout;
    logic          ce_n, oe_n, we_n, dout_oe;

    int n_tests = 0;
    int n_fail  = 0;
    logic exp_tog;

    always #5 clk = !clk;

    function automatic logic [7:0] mem(input logic [AW-1:0] a);
        return 8'((int'(a) * 29 + 90) & 255);
    endfunction

    assign arr_data = mem(rd_addr);

    flash_status_rdpath #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .op_busy(op_busy), .op_erase(op_erase),
        .ld_addr(ld_addr), .ld_data(ld_data), .ce_n(ce_n), .oe_n(oe_n),
        .we_n(we_n), .rd_addr(rd_addr), .arr_data(arr_data),
        .dout(dout), .dout_oe(dout_oe)
    );

    task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got oe=%0b data=%02h, expected oe=%0b data=%02h",
                     req, act[8], act[7:0], exp[8], exp[7:0]);
        end
    endtask

    task automatic finish_tb;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // one access: both lines low, sample a clock later, release one line
    task automatic do_read(input logic [AW-1:0] a, input bit via_ce, output logic [8:0] got);
        @(negedge clk);
        rd_addr = a; ce_n = 1'b0; oe_n = 1'b0;
        @(negedge clk);
        got = {dout_oe, dout};
        if (via_ce) ce_n = 1'b1; else oe_n = 1'b1;
    endtask

    task automatic start_op(input bit erase, input logic [AW-1:0] la, input logic [7:0] ld);
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1;
        op_busy = 1'b1; op_erase = erase; ld_addr = la; ld_data = ld;
        exp_tog = 1'b0;
        @(negedge clk);
    endtask

    task automatic end_op;
        @(negedge clk);
        op_busy = 1'b0;
    endtask

    function automatic logic [8:0] busy_exp(input bit erase, input logic [AW-1:0] a,
                                            input logic [AW-1:0] la, input logic [7:0] ld,
                                            input logic t);
        logic [7:0] v;
        v = mem(a);
        v[6] = t;
        if (erase) v[7] = 1'b0;
        else if (a == la) v[7] = !ld[7];
        return {1'b1, v};
    endfunction

    initial begin
        #2_000_000;
        n_tests++; n_fail++;
        $display("FAIL watchdog: got timeout, expected completion");
        finish_tb();
    end

    initial begin
        logic [8:0] got;
        logic [7:0] pats [4] = '{8'h00, 8'h80, 8'h5A, 8'hC3};
        rst_n = 1'b0; op_busy = 1'b0; op_erase = 1'b0; ld_addr = '0; ld_data = '0;
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; rd_addr = 4'd3; exp_tog = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 in reset", {dout_oe, dout}, 9'h000);
        ce_n = 1'b1; oe_n = 1'b1;
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", {dout_oe, dout}, 9'h000);

        // R2 idle sweep
        for (int a = 0; a < 16; a++) begin
            do_read(AW'(a), a[0], got);
            check("R2 idle read", got, {1'b1, mem(AW'(a))});
        end
        @(negedge clk);
        oe_n = 1'b1; ce_n = 1'b1;
        @(negedge clk);
        check("R2 no read", {dout_oe, dout}, 9'h000);

        // R3/R4/R6/R8 program sweeps
        for (int p = 0; p < 4; p++) begin
            logic [AW-1:0] la;
            la = AW'(p * 5 + 2);
            start_op(1'b0, la, pats[p]);
            for (int a = 0; a < 16; a++) begin
                exp_tog = !exp_tog;
                do_read(AW'(a), a[1], got);
                check(AW'(a) == la ? "R3 poll match R6" : "R4 poll other R6 R8",
                      got, busy_exp(1'b0, AW'(a), la, pats[p], exp_tog));
            end
            end_op();
            do_read(la, 1'b0, got);
            check("R9 done true data", got, {1'b1, mem(la)});
        end

        // R5 erase sweep
        start_op(1'b1, 4'd7, 8'hFF);
        for (int a = 0; a < 16; a++) begin
            exp_tog = !exp_tog;
            do_read(AW'(a), a[0], got);
            check("R5 erase bit7", got, busy_exp(1'b1, AW'(a), 4'd7, 8'hFF, exp_tog));
        end
        end_op();

        // R7 held access, R9 restart
        start_op(1'b0, 4'd9, 8'h80);
        @(negedge clk);
        rd_addr = 4'd9; ce_n = 1'b0; oe_n = 1'b0;
        exp_tog = 1'b1;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check("R7 held access R9 restart", {dout_oe, dout},
                  busy_exp(1'b0, 4'd9, 4'd9, 8'h80, exp_tog));
        end
        oe_n = 1'b1;
        // R9 idle gap: no drift
        repeat (6) @(negedge clk);
        exp_tog = !exp_tog;
        do_read(4'd4, 1'b1, got);
        check("R9 hold across gap", got, busy_exp(1'b0, 4'd4, 4'd9, 8'h80, exp_tog));

        // R8 strobes from chip select only, oe_n held low
        @(negedge clk);
        oe_n = 1'b0; ce_n = 1'b1; rd_addr = 4'd9;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            ce_n = 1'b0;
            exp_tog = !exp_tog;
            @(negedge clk);
            check("R8 ce strobe", {dout_oe, dout}, busy_exp(1'b0, 4'd9, 4'd9, 8'h80, exp_tog));
            ce_n = 1'b1;
        end

        // R10 write enable low blocks the read
        @(negedge clk);
        we_n = 1'b0; ce_n = 1'b0; oe_n = 1'b0;
        @(negedge clk);
        check("R10 we low no output", {dout_oe, dout}, 9'h000);
        ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
        exp_tog = !exp_tog;
        do_read(4'd9, 1'b1, got);
        check("R10 no toggle advance", got, busy_exp(1'b0, 4'd9, 4'd9, 8'h80, exp_tog));
        end_op();

        // R9 after completion: bit 6 follows the array, no toggling
        for (int k = 0; k < 3; k++) begin
            do_read(4'd9, 1'b0, got);
            check("R9 idle no toggle", got, {1'b1, mem(4'd9)});
        end

        // R9 new operation restarts toggle at the first-read value
        start_op(1'b0, 4'd1, 8'h00);
        exp_tog = 1'b1;
        do_read(4'd1, 1'b0, got);
        check("R9 restart first read", got, busy_exp(1'b0, 4'd1, 4'd1, 8'h00, exp_tog));
        end_op();

        repeat (2) @(negedge clk);
        finish_tb();
    end
endmodule